// File: doc/BRIEF.md
# Addressable Input Acquisition Port

This block collects up to eight byte-wide input variables for a downstream fuzzy inference engine. Each byte is handed over with a read strobe and a ready acknowledge. The port stores the byte in a register file that keeps its contents between elaboration cycles. In ordered mode the bytes fill the slots one after another, and an output shows the number of the slot that will be written next. In slave mode every byte comes with a 3-bit identifier, so the sender can deliver the inputs in any order. It can also end the round early with a last-input flag. Slots that are not refreshed in that round keep their old values.

When the round is complete, the port raises busy and holds it until the downstream engine reports that it is done. No new bytes are accepted in the meantime. The engine reads the stored bytes straight from the flattened variable bus. Busy can fall, or the off-line control can go low. A fixed number of cycles after either event, the port can drive a start-conversion pulse of programmable width to an external converter. The read strobe, the ready acknowledge, the last-input flag and the start-conversion pulse each have a configurable active level.

Top module: `inputAcqPort`

## Requirements
- R1: While idle, on-line and not already acknowledging, an active read strobe writes `dataIn` into its slot at that clock edge, and ready turns active from that edge on.
- R2: Ready stays active for at least MIN_ACQ (default 8) cycles after a capture. It drops at the first edge where the strobe is inactive and that minimum has elapsed, so each transfer takes at least MIN_ACQ cycles.
- R3: Ordered mode (`cfgSlave`=0) writes slot 0, 1, 2 … in turn. `nextId` shows the index of the next slot. Busy rises on the capture that brings the count to `cfgNumInputs` (1 to 8), and `nextId` then returns to 0.
- R4: Slave mode (`cfgSlave`=1) samples `idSel` with the data and writes slot `idSel`. An identifier of `cfgNumInputs` or above is acknowledged but not stored, and it does not count toward completion.
- R5: In slave mode, busy rises on the capture that has filled every identifier below `cfgNumInputs` at least once this round, in any order.
- R6: In slave mode, an active last-input flag sampled with the strobe ends the round at once. Slots not written this round keep their earlier values. In ordered mode the flag has no effect.
- R7: While busy is high or `offline` is high, an active read strobe is neither stored nor acknowledged.
- R8: Busy, once raised, holds until `elabDone` is sampled high. It falls at that edge.
- R9: Busy falling, or `offline` falling, starts a timer. If `autoMode` is low and `cfgPulseWidth` is nonzero, the start-conversion output becomes active CONV_DELAY (default 50) cycles after that edge and stays active for `cfgPulseWidth` cycles. A width of 0, or `autoMode` high at the trigger, produces no pulse.
- R10: Each `cfgPol*` bit gives the active level of its pin (1 = active high, 0 = active low). Ready and start-conversion idle at the inverse level.
- R11: `presetN` low clears every slot to 0, drops busy, ready and any pending pulse, and returns `nextId` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| presetN | input | 1 | Synchronous active-low preset |
| offline | input | 1 | High blocks acquisition; its falling edge triggers a pulse |
| autoMode | input | 1 | High suppresses the start-conversion pulse |
| rdPin | input | 1 | Read strobe, level set by cfgPolRd |
| lastInPin | input | 1 | Last-input flag, level set by cfgPolLast |
| idSel | input | 3 | Slot identifier in slave mode |
| dataIn | input | 8 | Input byte |
| elabDone | input | 1 | Downstream elaboration finished |
| cfgNumInputs | input | 4 | Configured input count, 1 to 8 |
| cfgSlave | input | 1 | 1 selects slave (addressed) mode |
| cfgPulseWidth | input | 8 | Pulse width in cycles, 0 disables |
| cfgPolRd | input | 1 | Active level of rdPin |
| cfgPolReady | input | 1 | Active level of readyPin |
| cfgPolLast | input | 1 | Active level of lastInPin |
| cfgPolConv | input | 1 | Active level of startConv |
| readyPin | output | 1 | Capture acknowledge |
| busy | output | 1 | Elaboration in progress |
| nextId | output | 3 | Next slot in ordered mode, 0 in slave mode |
| varsFlat | output | 64 | Stored bytes, slot i at bits 8i+7..8i |
| startConv | output | 1 | Start-conversion pulse |

## Verification
The hardest case to reach is a partial slave round. The bench has to show that a slot was left untouched across a round, and that a slot number outside the configured range was acknowledged yet neither stored nor counted. To get there, the bench first completes a full out-of-order round with distinct values. In the next round it refreshes only one slot and ends the round with the last-input flag. It then reads every slot from the variable bus. The start-conversion timing is checked by counting falling clock edges from the busy-fall edge and from the off-line-fall edge, under both pin polarities, with a zero width, and with the suppressing input high.

// File: rtl/acqPkg.sv
package acqPkg;
  localparam int ACQ_NUM_VARS = 8;
  localparam int ACQ_ID_W     = $clog2(ACQ_NUM_VARS);
  localparam int ACQ_CNT_W    = ACQ_ID_W + 1;

  typedef struct packed {
    logic                wrEn;
    logic [ACQ_ID_W-1:0] wrIdx;
  } dpCtrl_t;

  typedef enum logic [1:0] {
    CV_IDLE  = 2'd0,
    CV_WAIT  = 2'd1,
    CV_PULSE = 2'd2
  } convState_t;
endpackage

// File: rtl/acqDatapath.sv
module acqDatapath
  import acqPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           presetN,
  input  dpCtrl_t                        strobe,
  input  logic [DATA_W-1:0]              dataIn,
  output logic [ACQ_NUM_VARS*DATA_W-1:0] varsFlat
);
  for (genvar g = 0; g < ACQ_NUM_VARS; g++) begin : gSlot
    logic [DATA_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!presetN)
        slotQ <= '0;
      else if (strobe.wrEn && strobe.wrIdx == ACQ_ID_W'(g))
        slotQ <= dataIn;
    end
    assign varsFlat[g*DATA_W +: DATA_W] = slotQ;
  end

  // R6: a slot that receives no write keeps its value
  assert_slots_retained_R6: assert property (@(posedge clk) disable iff (!presetN)
    !strobe.wrEn |=> $stable(varsFlat));
endmodule

// File: rtl/acqConvPulse.sv
module acqConvPulse
  import acqPkg::*;
#(
  parameter int CONV_DELAY = 50,
  parameter int PW_W       = 8
) (
  input  logic            clk,
  input  logic            presetN,
  input  logic            trigger,
  input  logic            autoMode,
  input  logic [PW_W-1:0] cfgPulseWidth,
  output logic            pulseOn
);
  localparam int DLY_W = $clog2(CONV_DELAY + 1);

  convState_t       state;
  logic [DLY_W-1:0] waitCnt;
  logic [PW_W-1:0]  widCnt;

  always_ff @(posedge clk) begin
    if (!presetN) begin
      state   <= CV_IDLE;
      waitCnt <= '0;
      widCnt  <= '0;
    end else begin
      case (state)
        CV_IDLE: if (trigger && !autoMode && cfgPulseWidth != '0) begin
          state   <= CV_WAIT;
          waitCnt <= DLY_W'(CONV_DELAY - 1);
        end
        CV_WAIT: begin
          if (waitCnt == '0) begin
            if (cfgPulseWidth == '0) state <= CV_IDLE;
            else begin
              state  <= CV_PULSE;
              widCnt <= cfgPulseWidth - PW_W'(1);
            end
          end else waitCnt <= waitCnt - DLY_W'(1);
        end
        CV_PULSE: begin
          if (widCnt == '0) state <= CV_IDLE;
          else widCnt <= widCnt - PW_W'(1);
        end
        default: state <= CV_IDLE;
      endcase
    end
  end

  assign pulseOn = (state == CV_PULSE);

  // checker: length of the waiting phase before the pulse
  logic [DLY_W-1:0] waitLen;
  always_ff @(posedge clk) begin
    if (!presetN) waitLen <= '0;
    else if (state == CV_WAIT)
      waitLen <= (waitLen == DLY_W'(CONV_DELAY)) ? waitLen : waitLen + DLY_W'(1);
    else waitLen <= '0;
  end

  assert_pulse_delay_R9: assert property (@(posedge clk) disable iff (!presetN)
    $rose(pulseOn) |-> waitLen == DLY_W'(CONV_DELAY));
endmodule

// File: rtl/acqCtrl.sv
module acqCtrl
  import acqPkg::*;
#(
  parameter int MIN_ACQ = 8
) (
  input  logic                 clk,
  input  logic                 presetN,
  input  logic                 offline,
  input  logic                 rdAct,
  input  logic                 lastAct,
  input  logic [ACQ_ID_W-1:0]  idSel,
  input  logic [ACQ_CNT_W-1:0] cfgNumInputs,
  input  logic                 cfgSlave,
  input  logic                 elabDone,
  output dpCtrl_t              dpStrobe,
  output logic                 readyAct,
  output logic                 busy,
  output logic [ACQ_ID_W-1:0]  nextId,
  output logic                 convTrigger
);
  localparam int HOLD_W = $clog2(MIN_ACQ + 1);

  logic [ACQ_NUM_VARS-1:0] gotMask, needMask, idOneHot, seenAfter;
  logic [ACQ_CNT_W-1:0]    ordCount, ordNext;
  logic [HOLD_W-1:0]       holdCnt;
  logic                    offlinePrev;
  logic acceptOk, storeOk, idInRange, slaveDone, ordDone, finishAcq;

  always_comb begin
    for (int i = 0; i < ACQ_NUM_VARS; i++)
      needMask[i] = (ACQ_CNT_W'(i) < cfgNumInputs);
  end

  assign idOneHot  = ACQ_NUM_VARS'(1) << idSel;
  assign idInRange = ({1'b0, idSel} < cfgNumInputs);
  assign acceptOk  = rdAct && !readyAct && !busy && !offline;
  assign storeOk   = acceptOk && (!cfgSlave || idInRange);
  assign seenAfter = gotMask | (storeOk ? idOneHot : '0);
  assign ordNext   = ordCount + ACQ_CNT_W'(1);
  assign slaveDone = ((seenAfter & needMask) == needMask) || lastAct;
  assign ordDone   = (ordNext >= cfgNumInputs);
  assign finishAcq = acceptOk && (cfgSlave ? slaveDone : ordDone);

  assign dpStrobe.wrEn  = storeOk;
  assign dpStrobe.wrIdx = cfgSlave ? idSel : ordCount[ACQ_ID_W-1:0];
  assign nextId         = cfgSlave ? '0 : ordCount[ACQ_ID_W-1:0];
  assign convTrigger    = (busy && elabDone) || (offlinePrev && !offline);

  always_ff @(posedge clk) begin
    if (!presetN) begin
      readyAct    <= 1'b0;
      holdCnt     <= '0;
      busy        <= 1'b0;
      gotMask     <= '0;
      ordCount    <= '0;
      offlinePrev <= 1'b0;
    end else begin
      offlinePrev <= offline;
      if (acceptOk) begin
        readyAct <= 1'b1;
        holdCnt  <= HOLD_W'(MIN_ACQ - 1);
      end else if (readyAct) begin
        if (holdCnt != '0) holdCnt <= holdCnt - HOLD_W'(1);
        else if (!rdAct)   readyAct <= 1'b0;
      end
      if (finishAcq) begin
        busy     <= 1'b1;
        gotMask  <= '0;
        ordCount <= '0;
      end else if (acceptOk) begin
        if (cfgSlave) gotMask  <= seenAfter;
        else          ordCount <= ordNext;
      end
      if (busy && elabDone) busy <= 1'b0;
    end
  end

  // checker: cycles ready has been active
  logic [HOLD_W-1:0] readyLen;
  always_ff @(posedge clk) begin
    if (!presetN) readyLen <= '0;
    else if (readyAct)
      readyLen <= (readyLen == HOLD_W'(MIN_ACQ)) ? readyLen : readyLen + HOLD_W'(1);
    else readyLen <= '0;
  end

  assert_ready_needs_rd_R1: assert property (@(posedge clk) disable iff (!presetN)
    $rose(readyAct) |-> $past(rdAct));
  assert_ready_min_len_R2: assert property (@(posedge clk) disable iff (!presetN)
    $fell(readyAct) |-> readyLen >= HOLD_W'(MIN_ACQ));
  assert_no_store_busy_R7: assert property (@(posedge clk) disable iff (!presetN)
    dpStrobe.wrEn |-> (!busy && !offline));
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!presetN)
    (busy && !elabDone) |=> busy);
endmodule

// File: rtl/inputAcqPort.sv
module inputAcqPort
  import acqPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MIN_ACQ    = 8,
  parameter int CONV_DELAY = 50,
  parameter int PW_W       = 8
) (
  input  logic                           clk,
  input  logic                           presetN,
  input  logic                           offline,
  input  logic                           autoMode,
  input  logic                           rdPin,
  input  logic                           lastInPin,
  input  logic [ACQ_ID_W-1:0]            idSel,
  input  logic [DATA_W-1:0]              dataIn,
  input  logic                           elabDone,
  input  logic [ACQ_CNT_W-1:0]           cfgNumInputs,
  input  logic                           cfgSlave,
  input  logic [PW_W-1:0]                cfgPulseWidth,
  input  logic                           cfgPolRd,
  input  logic                           cfgPolReady,
  input  logic                           cfgPolLast,
  input  logic                           cfgPolConv,
  output logic                           readyPin,
  output logic                           busy,
  output logic [ACQ_ID_W-1:0]            nextId,
  output logic [ACQ_NUM_VARS*DATA_W-1:0] varsFlat,
  output logic                           startConv
);
  dpCtrl_t dpStrobe;
  logic rdAct, lastAct, readyAct, convTrigger, pulseOn;

  assign rdAct     = (rdPin == cfgPolRd);
  assign lastAct   = (lastInPin == cfgPolLast);
  assign readyPin  = readyAct ? cfgPolReady : ~cfgPolReady;
  assign startConv = pulseOn ? cfgPolConv : ~cfgPolConv;

  acqCtrl #(.MIN_ACQ(MIN_ACQ)) u_ctrl (
    .clk(clk), .presetN(presetN), .offline(offline), .rdAct(rdAct),
    .lastAct(lastAct), .idSel(idSel), .cfgNumInputs(cfgNumInputs),
    .cfgSlave(cfgSlave), .elabDone(elabDone), .dpStrobe(dpStrobe),
    .readyAct(readyAct), .busy(busy), .nextId(nextId),
    .convTrigger(convTrigger)
  );

  acqDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .presetN(presetN), .strobe(dpStrobe), .dataIn(dataIn),
    .varsFlat(varsFlat)
  );

  acqConvPulse #(.CONV_DELAY(CONV_DELAY), .PW_W(PW_W)) u_conv (
    .clk(clk), .presetN(presetN), .trigger(convTrigger), .autoMode(autoMode),
    .cfgPulseWidth(cfgPulseWidth), .pulseOn(pulseOn)
  );
endmodule

// File: tb/inputAcqPort_tb.sv
module inputAcqPort_tb;
  localparam int DLY = 50;

  logic clk = 1'b0;
  logic presetN, offline, autoMode, rdPin, lastInPin, elabDone;
  logic [2:0] idSel;
  logic [7:0] dataIn;
  logic [3:0] cfgNumInputs;
  logic cfgSlave;
  logic [7:0] cfgPulseWidth;
  logic cfgPolRd, cfgPolReady, cfgPolLast, cfgPolConv;
  logic readyPin, busy, startConv;
  logic [2:0] nextId;
  logic [63:0] varsFlat;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  inputAcqPort u_dut (
    .clk(clk), .presetN(presetN), .offline(offline), .autoMode(autoMode),
    .rdPin(rdPin), .lastInPin(lastInPin), .idSel(idSel), .dataIn(dataIn),
    .elabDone(elabDone), .cfgNumInputs(cfgNumInputs), .cfgSlave(cfgSlave),
    .cfgPulseWidth(cfgPulseWidth), .cfgPolRd(cfgPolRd),
    .cfgPolReady(cfgPolReady), .cfgPolLast(cfgPolLast),
    .cfgPolConv(cfgPolConv), .readyPin(readyPin), .busy(busy),
    .nextId(nextId), .varsFlat(varsFlat), .startConv(startConv)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] slot(input int i);
    return varsFlat[i*8 +: 8];
  endfunction

  function automatic bit readyOn();
    return readyPin == cfgPolReady;
  endfunction

  function automatic bit convOn();
    return startConv == cfgPolConv;
  endfunction

  // one handshake; hi = negedges with ready active after the strobe edge
  task automatic sendByte(input logic [2:0] id, input logic [7:0] d,
                          input bit last, output int hi);
    @(negedge clk);
    dataIn = d; idSel = id;
    lastInPin = last ? cfgPolLast : ~cfgPolLast;
    rdPin = cfgPolRd;
    @(negedge clk);
    rdPin = ~cfgPolRd;
    lastInPin = ~cfgPolLast;
    hi = 0;
    while (readyOn() && hi < 50) begin
      hi++;
      @(negedge clk);
    end
  endtask

  // caller has just set the trigger-causing input at a negedge
  task automatic measurePulse(output int dly, output int wid);
    int k = 1;
    @(negedge clk);
    elabDone = 1'b0;
    while (!convOn() && k < 300) begin
      @(negedge clk);
      k++;
    end
    wid = 0;
    if (k >= 300) dly = -1;
    else begin
      dly = k;
      while (convOn() && wid < 300) begin
        wid++;
        @(negedge clk);
      end
    end
  endtask

  task automatic doPreset();
    @(negedge clk);
    presetN = 1'b0;
    repeat (3) @(negedge clk);
    presetN = 1'b1;
  endtask

  task automatic testReset();
    check("R11 slots", varsFlat, 0);
    check("R11 busy", busy, 0);
    check("R11 ready", readyOn(), 0);
    check("R11 nextId", nextId, 0);
    check("R11 conv", convOn(), 0);
  endtask

  task automatic testOrdered();
    int hi, d, w;
    cfgSlave = 1'b0; cfgNumInputs = 4'd3; cfgPulseWidth = 8'd5;
    @(negedge clk);
    check("R3 nextId0", nextId, 0);
    sendByte(3'd7, 8'h11, 1'b1, hi);   // lastIn ignored, idSel ignored
    check("R2 ready length", hi, 8);
    check("R6 ordered last ignored", busy, 0);
    check("R3 nextId1", nextId, 1);
    sendByte(3'd0, 8'h22, 1'b0, hi);
    check("R3 nextId2", nextId, 2);
    check("R3 busy early", busy, 0);
    sendByte(3'd0, 8'h33, 1'b0, hi);
    check("R3 busy", busy, 1);
    check("R3 nextId reset", nextId, 0);
    check("R1 slot0", slot(0), 8'h11);
    check("R1 slot1", slot(1), 8'h22);
    check("R1 slot2", slot(2), 8'h33);
    sendByte(3'd0, 8'hFF, 1'b0, hi);
    check("R7 busy no ack", hi, 0);
    check("R7 busy no store", varsFlat, 64'h0000_0000_0033_2211);
    repeat (4) @(negedge clk);
    check("R8 busy holds", busy, 1);
    elabDone = 1'b1;
    measurePulse(d, w);
    check("R8 busy fell", busy, 0);
    check("R9 delay", d, DLY + 1);
    check("R9 width", w, 5);
  endtask

  task automatic testSlave();
    int hi, d, w;
    cfgSlave = 1'b1; cfgNumInputs = 4'd4; cfgPulseWidth = 8'd0;
    sendByte(3'd3, 8'hA3, 1'b0, hi);
    check("R4 ack", hi, 8);
    check("R4 nextId slave", nextId, 0);
    sendByte(3'd1, 8'hA1, 1'b0, hi);
    sendByte(3'd6, 8'hEE, 1'b0, hi);
    check("R4 out of range ack", hi, 8);
    check("R4 out of range not stored", slot(6), 0);
    check("R5 not done", busy, 0);
    sendByte(3'd0, 8'hA0, 1'b0, hi);
    check("R5 not done 3", busy, 0);
    sendByte(3'd2, 8'hA2, 1'b0, hi);
    check("R5 busy", busy, 1);
    check("R4 slots", varsFlat, 64'h0000_0000_A3A2_A1A0);
    elabDone = 1'b1;
    measurePulse(d, w);
    check("R9 zero width", d, -1);
    // partial round ended by lastIn
    sendByte(3'd1, 8'h55, 1'b1, hi);
    check("R6 lastIn busy", busy, 1);
    check("R6 retained", varsFlat, 64'h0000_0000_A3A2_55A0);
    cfgPulseWidth = 8'd3; autoMode = 1'b1;
    @(negedge clk);
    elabDone = 1'b1;
    measurePulse(d, w);
    check("R9 auto suppress", d, -1);
    autoMode = 1'b0;
  endtask

  task automatic testOffline();
    int hi, d, w;
    @(negedge clk);
    offline = 1'b1;
    sendByte(3'd0, 8'h99, 1'b0, hi);
    check("R7 offline no ack", hi, 0);
    check("R7 offline no store", slot(0), 8'hA0);
    cfgPulseWidth = 8'd4;
    @(negedge clk);
    offline = 1'b0;
    measurePulse(d, w);
    check("R9 offline delay", d, DLY + 1);
    check("R9 offline width", w, 4);
  endtask

  task automatic testPolarity();
    int hi, d, w;
    @(negedge clk);
    cfgPolRd = 1'b0; cfgPolReady = 1'b0; cfgPolLast = 1'b0; cfgPolConv = 1'b0;
    rdPin = 1'b1; lastInPin = 1'b1;
    cfgSlave = 1'b0; cfgNumInputs = 4'd1; cfgPulseWidth = 8'd2;
    @(negedge clk);
    check("R10 ready idle high", readyPin, 1);
    check("R10 conv idle high", startConv, 1);
    sendByte(3'd0, 8'h77, 1'b0, hi);
    check("R10 low-active handshake", hi, 8);
    check("R10 stored", slot(0), 8'h77);
    check("R10 busy", busy, 1);
    elabDone = 1'b1;
    measurePulse(d, w);
    check("R10 conv low delay", d, DLY + 1);
    check("R10 conv low width", w, 2);
  endtask

  task automatic testPresetMid();
    doPreset();
    @(negedge clk);
    check("R11 preset clears slots", varsFlat, 0);
    check("R11 preset busy", busy, 0);
  endtask

  initial begin
    presetN = 1'b0; offline = 1'b0; autoMode = 1'b0; elabDone = 1'b0;
    cfgPolRd = 1'b1; cfgPolReady = 1'b1; cfgPolLast = 1'b1; cfgPolConv = 1'b1;
    rdPin = 1'b0; lastInPin = 1'b0; idSel = '0; dataIn = '0;
    cfgNumInputs = 4'd3; cfgSlave = 1'b0; cfgPulseWidth = 8'd5;
    doPreset();
    @(negedge clk);
    testReset();
    testOrdered();
    testSlave();
    testOffline();
    testPolarity();
    testPresetMid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule